// File: doc/BRIEF.md
# Interleaved Multicell Gate Modulator with Fault Reconfiguration

This block drives the switches of one leg of a series-connected multicell (flying-capacitor) converter. Each cell gets its own triangular carrier, and every carrier comes from one shared master phase counter plus a per-cell offset. Every carrier is compared against the same duty reference. The carriers are spread evenly over one carrier period, so with n active cells the leg output switches at n times the rate of a single cell. Each cell drives a complementary upper/lower gate pair.

A cell flagged as short-circuited is pinned straight away, with its upper switch on and its lower switch off, and it drops out of the interleave. The offsets of the cells that remain are then spread evenly over the period. This new spread takes effect only when the master carrier reaches its valley, so the leg keeps running through the change. An open-circuit flag on any cell, or a stop request, turns every gate of the leg off. Two status outputs report the number of cells in the interleave and the phase step in use.

Top module: `pscpwm_leg`

## Requirements
- R1: While reset is high, every gate output is low. On the first edge after reset, the status shows all cells active with a phase step of floor(2·PEAK/N_CELLS).
- R2: The master phase p counts 0,1,…,2·PEAK−1 and then wraps to 0. Cell k uses q=(p+off_k) mod 2·PEAK and carrier c = q if q≤PEAK, else 2·PEAK−q. In normal operation gate_hi[k] is 1 when duty ≥ c, including the case of equality, and gate_lo[k] is its complement.
- R3: The healthy cell of rank r, counting healthy cells from bit 0 upward, has offset off = r·step, where step = floor(2·PEAK/n) and n is the number of healthy cells.
- R4: With all three cells healthy, the step is one third of the carrier period. With PEAK=12 this is 8 ticks out of 24.
- R5: The active count, the step and the offsets are reloaded only on a clock edge at which the master phase is 0. A change of the short mask at any other time leaves them unchanged until that edge.
- R6: A cell whose short_mask bit is 1 drives gate_hi=1 and gate_lo=0 from the same cycle on, unless the leg is stopped. It is excluded from the healthy count.
- R7: If any open_mask bit is 1, all gate_hi and gate_lo outputs are 0 in that same cycle. No reconfiguration results from an open-circuit flag.
- R8: While stop is 1, all gate outputs are 0. Modulation resumes on the current carriers once stop returns to 0.
- R9: active_cnt reports the number of cells in the applied interleave, and phase_step reports the applied step in master ticks.
- R10: With every cell shorted, the next reload gives active_cnt=0 and phase_step=0.
- R11: With duty=0, a healthy cell's upper switch is on for exactly one tick per carrier period, the tick where its carrier is 0. With duty ≥ PEAK it is on for every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock, one master phase tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| duty | input | CW | Shared compare reference, 0..PEAK |
| short_mask | input | N_CELLS | Per-cell short-circuit flag: hold the cell and remove it from the interleave |
| open_mask | input | N_CELLS | Per-cell open-circuit flag: any set bit stops the leg |
| stop | input | 1 | Leg stop request, all gates off |
| gate_hi | output | N_CELLS | Upper switch command per cell |
| gate_lo | output | N_CELLS | Lower switch command per cell |
| active_cnt | output | $clog2(N_CELLS+1) | Number of cells in the applied interleave |
| phase_step | output | CW | Applied carrier phase step in master ticks |

## Verification
On every cycle the assertions check the following properties: the two switches of a pair are never on together; a stop or open flag clears the leg; shorted cells are pinned high; the status changes only after a valley tick; and the phase and the count stay within range. The cell offsets, the rank-based spacing after a loss, and the exact compare edges come from arithmetic on the carrier. Only the bench's reference model can show these, by tracking the master phase and the reload instants. The same holds for the duty extremes, which the bench exercises over whole carrier periods.

// File: rtl/pscpwm_pkg.sv
package pscpwm_pkg;

    typedef enum logic [1:0] {
        DRV_OFF  = 2'd0,
        DRV_PWM  = 2'd1,
        DRV_HOLD = 2'd2
    } drv_mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    // Bring a phase sum back into one carrier period (the sum is below two spans).
    function automatic int unsigned wrap_phase(int unsigned sum, int unsigned span);
        return (sum >= span) ? sum - span : sum;
    endfunction

    // Fold a phase position into a rising/falling triangle value.
    function automatic int unsigned fold_tri(int unsigned q, int unsigned peak, int unsigned span);
        return (q <= peak) ? q : span - q;
    endfunction

    // Priority: reset, stop, open fault > short hold > modulation.
    function automatic drv_mode_e pick_mode(logic rst, logic stop, logic any_open, logic shorted);
        if (rst || stop || any_open) return DRV_OFF;
        if (shorted)                 return DRV_HOLD;
        return DRV_PWM;
    endfunction

endpackage

// File: rtl/pscpwm_phase_gen.sv
module pscpwm_phase_gen #(
    parameter int CW   = 16,
    parameter int SPAN = 12500
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] phase,
    output logic          at_valley
);
    localparam logic [CW-1:0] LAST = CW'(SPAN - 1);

    always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    assign at_valley = (phase == '0);
endmodule

// File: rtl/pscpwm_planner.sv
module pscpwm_planner #(
    parameter int N_CELLS = 3,
    parameter int CW      = 16,
    parameter int SPAN    = 12500,
    localparam int CNTW   = $clog2(N_CELLS + 1)
) (
    input  logic [N_CELLS-1:0]         healthy,
    output logic [CNTW-1:0]            cnt,
    output logic [CW-1:0]              step,
    output logic [N_CELLS-1:0][CW-1:0] off
);
    logic [CW-1:0] acc;

    always_comb begin
        cnt = '0;
        for (int k = 0; k < N_CELLS; k++)
            cnt = cnt + CNTW'(healthy[k]);
        // Constant divisions only: one per possible count.
        step = '0;
        for (int i = 1; i <= N_CELLS; i++)
            if (cnt == CNTW'(i)) step = CW'(SPAN / i);
        acc = '0;
        for (int k = 0; k < N_CELLS; k++) begin
            off[k] = acc;
            if (healthy[k]) acc = acc + step;
        end
    end
endmodule

// File: rtl/pscpwm_cell.sv
module pscpwm_cell
    import pscpwm_pkg::*;
#(
    parameter int CW   = 16,
    parameter int PEAK = 6250,
    localparam int SPAN = 2 * PEAK
) (
    input  logic [CW-1:0] phase,
    input  logic [CW-1:0] off,
    input  logic [CW-1:0] duty,
    input  drv_mode_e     mode,
    output gate_pair_t    gate
);
    int unsigned q;
    int unsigned carrier;

    always_comb begin
        q       = wrap_phase(32'(phase) + 32'(off), SPAN);
        carrier = fold_tri(q, PEAK, SPAN);
        unique case (mode)
            DRV_PWM: begin
                gate.hi = (32'(duty) >= carrier);
                gate.lo = ~gate.hi;
            end
            DRV_HOLD: begin
                gate.hi = 1'b1;
                gate.lo = 1'b0;
            end
            default: begin
                gate.hi = 1'b0;
                gate.lo = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pscpwm_leg.sv
module pscpwm_leg
    import pscpwm_pkg::*;
#(
    parameter int N_CELLS = 3,
    parameter int CW      = 16,
    parameter int PEAK    = 6250,
    localparam int CNTW   = $clog2(N_CELLS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CW-1:0]      duty,
    input  logic [N_CELLS-1:0] short_mask,
    input  logic [N_CELLS-1:0] open_mask,
    input  logic               stop,
    output logic [N_CELLS-1:0] gate_hi,
    output logic [N_CELLS-1:0] gate_lo,
    output logic [CNTW-1:0]    active_cnt,
    output logic [CW-1:0]      phase_step
);
    localparam int SPAN = 2 * PEAK;

    logic [CW-1:0]              phase;
    logic                       at_valley;
    logic [N_CELLS-1:0]         plan_healthy;
    logic [CNTW-1:0]            plan_cnt;
    logic [CW-1:0]              plan_step;
    logic [N_CELLS-1:0][CW-1:0] plan_off;
    logic [N_CELLS-1:0][CW-1:0] cfg_off;
    logic                       any_open;

    pscpwm_phase_gen #(.CW(CW), .SPAN(SPAN)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .at_valley (at_valley)
    );

    assign plan_healthy = rst ? '1 : ~short_mask;

    pscpwm_planner #(.N_CELLS(N_CELLS), .CW(CW), .SPAN(SPAN)) u_plan (
        .healthy (plan_healthy),
        .cnt     (plan_cnt),
        .step    (plan_step),
        .off     (plan_off)
    );

    // Interleave changes are committed only at the master valley.
    always_ff @(posedge clk) begin
        if (rst || at_valley) begin
            active_cnt <= plan_cnt;
            phase_step <= plan_step;
            cfg_off    <= plan_off;
        end
    end

    assign any_open = |open_mask;

    for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
        gate_pair_t pair;
        drv_mode_e  mode;
        assign mode = pick_mode(rst, stop, any_open, short_mask[k]);
        pscpwm_cell #(.CW(CW), .PEAK(PEAK)) u_cell (
            .phase (phase),
            .off   (cfg_off[k]),
            .duty  (duty),
            .mode  (mode),
            .gate  (pair)
        );
        assign gate_hi[k] = pair.hi;
        assign gate_lo[k] = pair.lo;
    end
endmodule

// File: rtl/pscpwm_leg_chk.sv
module pscpwm_leg_chk #(
    parameter int N_CELLS = 3,
    parameter int CW      = 16,
    parameter int PEAK    = 6250,
    localparam int CNTW   = $clog2(N_CELLS + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               stop,
    input logic [N_CELLS-1:0] short_mask,
    input logic [N_CELLS-1:0] open_mask,
    input logic [N_CELLS-1:0] gate_hi,
    input logic [N_CELLS-1:0] gate_lo,
    input logic [CNTW-1:0]    active_cnt,
    input logic [CW-1:0]      phase_step,
    input logic [CW-1:0]      phase
);
    localparam int SPAN = 2 * PEAK;

    AST_RESET_GATES_OFF: assert property (@(posedge clk)
        rst |-> (gate_hi == '0 && gate_lo == '0)); // R1

    AST_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (gate_hi & gate_lo) == '0); // R2

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(phase) < SPAN); // R2

    AST_RELOAD_AT_VALLEY: assert property (@(posedge clk) disable iff (rst)
        (phase != '0) |=> ($stable(active_cnt) && $stable(phase_step))); // R5

    AST_SHORT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!stop && open_mask == '0) |->
            ((gate_hi & short_mask) == short_mask && (gate_lo & short_mask) == '0)); // R6

    AST_OPEN_SAFE_STOP: assert property (@(posedge clk) disable iff (rst)
        (open_mask != '0) |-> (gate_hi == '0 && gate_lo == '0)); // R7

    AST_STOP_OFF: assert property (@(posedge clk) disable iff (rst)
        stop |-> (gate_hi == '0 && gate_lo == '0)); // R8

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(active_cnt) <= N_CELLS); // R9
endmodule

bind pscpwm_leg pscpwm_leg_chk #(.N_CELLS(N_CELLS), .CW(CW), .PEAK(PEAK)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stop       (stop),
    .short_mask (short_mask),
    .open_mask  (open_mask),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo),
    .active_cnt (active_cnt),
    .phase_step (phase_step),
    .phase      (phase)
);

// File: tb/pscpwm_leg_test.sv
`timescale 1ns/1ps
module pscpwm_leg_test;
    localparam int N    = 3;
    localparam int CW   = 16;
    localparam int PEAK = 12;
    localparam int SPAN = 2 * PEAK;
    localparam int CNTW = $clog2(N + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [CW-1:0]   duty = '0;
    logic [N-1:0]    short_mask = '0;
    logic [N-1:0]    open_mask = '0;
    logic            stop = 1'b0;
    logic [N-1:0]    gate_hi, gate_lo;
    logic [CNTW-1:0] active_cnt;
    logic [CW-1:0]   phase_step;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    bit auto_chk = 0;

    // Reference model state
    int m_p;
    int m_cnt;
    int m_step;
    int m_off [N];

    always #2.5 clk = ~clk;

    pscpwm_leg #(.N_CELLS(N), .CW(CW), .PEAK(PEAK)) uut (
        .clk(clk), .rst(rst), .duty(duty), .short_mask(short_mask),
        .open_mask(open_mask), .stop(stop), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .active_cnt(active_cnt), .phase_step(phase_step)
    );

    task automatic check(input string req, input int got, input int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    function automatic void plan(input logic [N-1:0] h);
        int acc;
        m_cnt = $countones(h);
        m_step = (m_cnt == 0) ? 0 : SPAN / m_cnt;
        acc = 0;
        for (int k = 0; k < N; k++) begin
            m_off[k] = acc;
            if (h[k]) acc += m_step;
        end
    endfunction

    function automatic int carrier_of(input int k);
        int q;
        q = (m_p + m_off[k]) % SPAN;
        return (q <= PEAK) ? q : SPAN - q;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_p = 0;
            plan('1);
        end else begin
            if (m_p == 0) plan(~short_mask);
            m_p = (m_p + 1) % SPAN;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (auto_chk) begin
            logic [N-1:0] eh, el;
            string tag;
            for (int k = 0; k < N; k++) begin
                if (rst || stop || open_mask != '0) begin
                    eh[k] = 0; el[k] = 0;
                end else if (short_mask[k]) begin
                    eh[k] = 1; el[k] = 0;
                end else begin
                    eh[k] = (int'(duty) >= carrier_of(k));
                    el[k] = ~eh[k];
                end
            end
            tag = rst ? "R1" : stop ? "R8" : (open_mask != '0) ? "R7" : "R2/R3";
            if (!rst && !stop && open_mask == '0) begin
                check("R6 short cells", int'(gate_hi & short_mask), int'(eh & short_mask));
            end
            check({tag, " gate_hi"}, int'(gate_hi), int'(eh));
            check({tag, " gate_lo"}, int'(gate_lo), int'(el));
            if (!rst) begin
                check("R5/R9 active_cnt", int'(active_cnt), m_cnt);
                check("R5/R9 phase_step", int'(phase_step), m_step);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int hits;
        void'($urandom(32'd7453));
        auto_chk = 1;
        tick(3);
        @(negedge clk);
        check("R1 reset gate_hi", int'(gate_hi), 0);
        check("R1 reset gate_lo", int'(gate_lo), 0);
        @(posedge clk); #1;
        rst = 0;
        tick(1);
        @(negedge clk);
        check("R1 count after reset", int'(active_cnt), N);
        check("R4 three-cell step", int'(phase_step), SPAN / 3);

        // R11: duty extremes over one full period per cell
        duty = '0;
        tick(SPAN);
        hits = 0;
        for (int i = 0; i < SPAN; i++) begin
            @(negedge clk);
            hits += int'(gate_hi[1]);
        end
        check("R11 duty zero upper ticks", hits, 1);
        duty = CW'(PEAK);
        tick(1);
        hits = 0;
        for (int i = 0; i < SPAN; i++) begin
            @(negedge clk);
            hits += int'(gate_hi[2]);
        end
        check("R11 duty full upper ticks", hits, SPAN);

        // R5/R6: short cell 1 mid-period, status holds until valley
        duty = CW'(5);
        while (m_p != 5) tick(1);
        short_mask = 3'b010;
        tick(1);
        @(negedge clk);
        check("R5 count held before valley", int'(active_cnt), 3);
        check("R6 shorted cell held", int'(gate_hi[1]), 1);
        tick(SPAN);
        @(negedge clk);
        check("R3 two-cell count", int'(active_cnt), 2);
        check("R3 two-cell step", int'(phase_step), SPAN / 2);
        tick(2 * SPAN);

        // R10: all cells shorted
        short_mask = '1;
        tick(SPAN + 1);
        @(negedge clk);
        check("R10 empty count", int'(active_cnt), 0);
        check("R10 empty step", int'(phase_step), 0);
        short_mask = '0;
        tick(SPAN + 2);

        // R7 and R8
        open_mask = 3'b100;
        tick(3);
        @(negedge clk);
        check("R7 open stops leg", int'(gate_hi | gate_lo), 0);
        check("R7 no reconfiguration", int'(active_cnt), 3);
        open_mask = '0;
        stop = 1;
        tick(3);
        @(negedge clk);
        check("R8 stop clears gates", int'(gate_hi | gate_lo), 0);
        stop = 0;
        tick(2);

        // Random phase with model comparison every cycle
        for (int i = 0; i < 6000; i++) begin
            duty = CW'($urandom_range(0, PEAK + 1));
            if ($urandom_range(0, 39) == 0) short_mask = N'($urandom_range(0, (1 << N) - 1));
            open_mask = ($urandom_range(0, 199) == 0) ? N'(1 << $urandom_range(0, N - 1)) : '0;
            stop = ($urandom_range(0, 99) == 0);
            tick(1);
        end

        done = 1;
        auto_chk = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule